// File: doc/BRIEF.md
# PCI Interrupt Router and Gate

This block collects level-sensitive INTA to INTD requests from PCI devices and folds them onto a flat vector of 32 interrupt lines. Requests arrive from three places: devices on the primary bus and devices behind each of two secondary bridges. Each source supplies its device/function number and its four INTx levels.

The primary bus and the bridges place their lines differently. A primary device lands in the low or the high half of the vector, selected by the lowest device/function bit. A device behind a bridge gets four consecutive lines chosen by its slot bits. The 32 lines are grouped in fours. Each group is gated by one enable bit taken from an interrupt-map register held elsewhere.

The gated result is registered, so the outputs are clean levels for a downstream interrupt controller. There are no states. The router is a fixed combinational map followed by one register stage with no transitions.

Top module: `irq_route_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `irq_out` is 0, whatever the sources and enables.
- R2: A primary-bus source whose device/function bit 0 is 0 drives its INTx line k (k = 0 for INTA to 3 for INTD, bit k of its intx field) onto output k.
- R3: A primary-bus source whose device/function bit 0 is 1 drives its INTx line k onto output 16 + k.
- R4: For a primary-bus source, device/function bits 7:1 have no effect on which output is driven.
- R5: A source behind a secondary bridge drives its INTx line k onto output 4 * devfn[4:3] + k. Device/function bits 7:5 and 2:0 have no effect.
- R6: Both secondary bridges use the R5 mapping, independently of each other.
- R7: When several sources map to the same output, that output is the OR of their levels.
- R8: Output n can be high only when enable bit n / 4 of `grp_en` is 1. When that bit is 0 the output is low whatever the input levels.
- R9: A change on any source level or enable bit appears on `irq_out` at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_devfn | input | N_PRI*8 | Device/function number of each primary-bus source, source i in bits 8i+7:8i |
| pri_intx | input | N_PRI*4 | INTA..INTD levels of each primary-bus source, source i in bits 4i+3:4i |
| br0_devfn | input | N_BR*8 | Device/function number of each source behind bridge 0 |
| br0_intx | input | N_BR*4 | INTx levels of each source behind bridge 0 |
| br1_devfn | input | N_BR*8 | Device/function number of each source behind bridge 1 |
| br1_intx | input | N_BR*4 | INTx levels of each source behind bridge 1 |
| grp_en | input | 8 | One enable per group of four outputs, bit g gating outputs 4g..4g+3 |
| irq_out | output | 32 | Registered, gated interrupt levels |

## Verification
The hardest case to reach is an output shared by several sources from different buses, where one source drops while another still holds the line. The bench first places a primary device with bit 0 clear and a bridge device in slot 0 on the same output. It then releases them one at a time and checks that the line stays high until the last source lets go. Enable-gating timing is reached by leaving many groups requesting and changing `grp_en` between clock edges. The output is sampled just before and just after the next rising edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int unsigned INTX_W  = 4;
    localparam int unsigned DEVFN_W = 8;

    typedef enum logic {
        SRC_PRIMARY = 1'b0,
        SRC_BRIDGE  = 1'b1
    } src_kind_e;
endpackage

// File: rtl/irq_src_mapper.sv
module irq_src_mapper
    import irq_route_pkg::*;
#(
    parameter src_kind_e   KIND      = SRC_PRIMARY,
    parameter int unsigned NUM_OUT   = 32,
    parameter int unsigned HI_OFFSET = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEVFN_W-1:0]     devfn,
    input  logic [INTX_W-1:0]      intx,
    output logic [NUM_OUT-1:0]     lines
);
    localparam int unsigned SEL_W = $clog2(NUM_OUT);

    int unsigned base;
    logic        unused_devfn_bits;

    generate
        if (KIND == SRC_PRIMARY) begin : g_primary
            // half of the vector selected by the function-number lsb (R2, R3, R4)
            assign base = devfn[0] ? HI_OFFSET : 0;
        end else begin : g_bridge
            // four consecutive lines per slot (R5)
            assign base = 32'(devfn[4:3]) * INTX_W;
        end
    endgenerate

    assign unused_devfn_bits = ^devfn;

    always_comb begin
        int unsigned idx;
        lines = '0;
        for (int k = 0; k < INTX_W; k++) begin
            idx = base + 32'(k);
            if (intx[k] && idx < NUM_OUT) begin
                lines[idx[SEL_W-1:0]] = 1'b1;
            end
        end
    end

    // R2
    map_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lines) <= $countones(intx));
    // R7
    map_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lines) |-> (|intx));
endmodule

// File: rtl/irq_gate_reg.sv
module irq_gate_reg #(
    parameter int unsigned NUM_OUT = 32,
    parameter int unsigned GRP_W   = 4,
    parameter int unsigned NUM_GRP = NUM_OUT / GRP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_OUT-1:0]   raw,
    input  logic [NUM_GRP-1:0]   grp_en,
    output logic [NUM_OUT-1:0]   irq_out
);
    logic [NUM_OUT-1:0] en_mask;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            assign en_mask[g*GRP_W +: GRP_W] = {GRP_W{grp_en[g]}};

            // R8
            grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|irq_out[g*GRP_W +: GRP_W]) |-> $past(grp_en[g]));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= '0;
        end else begin
            irq_out <= raw & en_mask;
        end
    end

    // R9
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_out & ~$past(irq_out))) |-> $past(|raw));
    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> (irq_out == '0));
endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate
    import irq_route_pkg::*;
#(
    parameter int unsigned N_PRI     = 2,
    parameter int unsigned N_BR      = 2,
    parameter int unsigned NUM_OUT   = 32,
    parameter int unsigned GRP_W     = 4,
    parameter int unsigned HI_OFFSET = 16,
    parameter int unsigned NUM_GRP   = NUM_OUT / GRP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PRI*DEVFN_W-1:0]   pri_devfn,
    input  logic [N_PRI*INTX_W-1:0]    pri_intx,
    input  logic [N_BR*DEVFN_W-1:0]    br0_devfn,
    input  logic [N_BR*INTX_W-1:0]     br0_intx,
    input  logic [N_BR*DEVFN_W-1:0]    br1_devfn,
    input  logic [N_BR*INTX_W-1:0]     br1_intx,
    input  logic [NUM_GRP-1:0]         grp_en,
    output logic [NUM_OUT-1:0]         irq_out
);
    localparam int unsigned N_SRC = N_PRI + 2 * N_BR;

    logic [NUM_OUT-1:0] src_lines [N_SRC];
    logic [NUM_OUT-1:0] raw;

    generate
        for (genvar i = 0; i < N_PRI; i++) begin : g_pri
            irq_src_mapper #(.KIND(SRC_PRIMARY), .NUM_OUT(NUM_OUT), .HI_OFFSET(HI_OFFSET)) map_i (
                .clk   (clk),
                .rst_n (rst_n),
                .devfn (pri_devfn[i*DEVFN_W +: DEVFN_W]),
                .intx  (pri_intx[i*INTX_W +: INTX_W]),
                .lines (src_lines[i])
            );
        end
        for (genvar i = 0; i < N_BR; i++) begin : g_br
            // R6: both bridges share one mapping
            irq_src_mapper #(.KIND(SRC_BRIDGE), .NUM_OUT(NUM_OUT), .HI_OFFSET(HI_OFFSET)) map0_i (
                .clk   (clk),
                .rst_n (rst_n),
                .devfn (br0_devfn[i*DEVFN_W +: DEVFN_W]),
                .intx  (br0_intx[i*INTX_W +: INTX_W]),
                .lines (src_lines[N_PRI + i])
            );
            irq_src_mapper #(.KIND(SRC_BRIDGE), .NUM_OUT(NUM_OUT), .HI_OFFSET(HI_OFFSET)) map1_i (
                .clk   (clk),
                .rst_n (rst_n),
                .devfn (br1_devfn[i*DEVFN_W +: DEVFN_W]),
                .intx  (br1_intx[i*INTX_W +: INTX_W]),
                .lines (src_lines[N_PRI + N_BR + i])
            );
        end
    endgenerate

    // R7: shared outputs are the OR of their sources
    always_comb begin
        raw = '0;
        for (int s = 0; s < N_SRC; s++) begin
            raw = raw | src_lines[s];
        end
    end

    irq_gate_reg #(.NUM_OUT(NUM_OUT), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw),
        .grp_en  (grp_en),
        .irq_out (irq_out)
    );

    // R8
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grp_en) == '0) |-> (irq_out == '0));
    // R9
    quiet_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pri_intx) == '0 && $past(br0_intx) == '0 && $past(br1_intx) == '0)
        |-> (irq_out == '0));
endmodule

// File: tb/irq_route_gate_tb_top.sv
`timescale 1ns/1ps
module irq_route_gate_tb_top;
    localparam int N_PRI = 2;
    localparam int N_BR  = 2;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [N_PRI*8-1:0]   pri_devfn;
    logic [N_PRI*4-1:0]   pri_intx;
    logic [N_BR*8-1:0]    br0_devfn;
    logic [N_BR*4-1:0]    br0_intx;
    logic [N_BR*8-1:0]    br1_devfn;
    logic [N_BR*4-1:0]    br1_intx;
    logic [7:0]           grp_en;
    logic [31:0]          irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_route_gate #(.N_PRI(N_PRI), .N_BR(N_BR)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pri_devfn (pri_devfn),
        .pri_intx  (pri_intx),
        .br0_devfn (br0_devfn),
        .br0_intx  (br0_intx),
        .br1_devfn (br1_devfn),
        .br1_intx  (br1_intx),
        .grp_en    (grp_en),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] exp);
        n_checks++;
        if (irq_out !== exp) begin
            n_fails++;
            $display("FAIL %s: irq_out=%h expected=%h", req, irq_out, exp);
        end
    endtask

    task automatic clear_src();
        pri_devfn = '0; pri_intx = '0;
        br0_devfn = '0; br0_intx = '0;
        br1_devfn = '0; br1_intx = '0;
    endtask

    // settle: inputs changed at a negedge, sample at the following negedge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        grp_en = 8'hFF;
        pri_devfn = 16'h0100; pri_intx = 8'hFF;
        br0_devfn = '0; br0_intx = 8'hFF;
        br1_devfn = '0; br1_intx = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 reset holds outputs low", 32'h0);
        clear_src();
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", 32'h0);
    endtask

    task automatic t_pri_low();
        clear_src();
        pri_devfn[7:0] = 8'h08; pri_intx[3:0] = 4'b0101;
        step();
        chk("R2 primary low half", 32'h0000_0005);
    endtask

    task automatic t_pri_high();
        clear_src();
        pri_devfn[15:8] = 8'h09; pri_intx[7:4] = 4'b1010;
        step();
        chk("R3 primary high half", 32'h000A_0000);
    endtask

    task automatic t_pri_bits();
        clear_src();
        pri_devfn[7:0] = 8'hFE; pri_intx[3:0] = 4'b0001;
        step();
        chk("R4 upper devfn bits ignored, bit0 clear", 32'h0000_0001);
        pri_devfn[7:0] = 8'h01; pri_intx[3:0] = 4'b1000;
        step();
        chk("R4 bit0 set alone", 32'h0008_0000);
    endtask

    task automatic t_bridge();
        clear_src();
        br0_devfn[7:0] = 8'h18; br0_intx[3:0] = 4'b0001;
        step();
        chk("R5 bridge slot 3", 32'h0000_1000);
        clear_src();
        br0_devfn[15:8] = 8'h11; br0_intx[7:4] = 4'b1000;
        step();
        chk("R5 bridge slot 2, low bits ignored", 32'h0000_0800);
        clear_src();
        br1_devfn[7:0] = 8'h08; br1_intx[3:0] = 4'b0011;
        br1_devfn[15:8] = 8'hE7; br1_intx[7:4] = 4'b0100;
        step();
        chk("R6 second bridge mapping", 32'h0000_0034);
    endtask

    task automatic t_or();
        clear_src();
        pri_devfn[7:0] = 8'h00; pri_intx[3:0] = 4'b0001;
        br0_devfn[7:0] = 8'h00; br0_intx[3:0] = 4'b0001;
        step();
        chk("R7 two sources share line", 32'h0000_0001);
        pri_intx[3:0] = 4'b0000;
        step();
        chk("R7 one source remains", 32'h0000_0001);
        br0_intx[3:0] = 4'b0000;
        step();
        chk("R7 all released", 32'h0000_0000);
    endtask

    task automatic fill_three_groups();
        clear_src();
        pri_devfn[7:0] = 8'h01; pri_intx[3:0] = 4'hF;
        br0_devfn[7:0] = 8'h18; br0_intx[3:0] = 4'hF;
        br1_devfn[7:0] = 8'h00; br1_intx[3:0] = 4'hF;
    endtask

    task automatic t_gate();
        fill_three_groups();
        grp_en = 8'h00;
        step();
        chk("R8 all groups disabled", 32'h0);
        grp_en = 8'h10;
        step();
        chk("R8 only group 4", 32'h000F_0000);
        grp_en = 8'h08;
        step();
        chk("R8 only group 3", 32'h0000_F000);
        grp_en = 8'hEE;
        step();
        chk("R8 group 0 and 4 off", 32'h0000_F000);
    endtask

    task automatic t_latency();
        fill_three_groups();
        grp_en = 8'h00;
        step();
        grp_en = 8'hFF;
        #1;
        chk("R9 enable not seen before edge", 32'h0);
        step();
        chk("R9 enable seen after edge", 32'h000F_F00F);
        clear_src();
        #1;
        chk("R9 input drop not seen before edge", 32'h000F_F00F);
        step();
        chk("R9 input drop seen after edge", 32'h0);
    endtask

    initial begin
        clear_src();
        grp_en = 8'hFF;
        rst_n = 1'b0;
        t_reset();
        grp_en = 8'hFF;
        t_pri_low();
        t_pri_high();
        t_pri_bits();
        t_bridge();
        t_or();
        t_gate();
        grp_en = 8'hFF;
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule